// File: doc/BRIEF.md
# Bridge Fault and Sleep Supervisor

This block guards the enables of a set of power bridges, two by default. It watches an active-low sleep request, a pair of thermal comparator flags and one overcurrent detector per bridge. From these it decides whether the bridges may conduct, whether the shared fault line is pulled low, and whether the block has finished waking up.

Two fault policies run side by side. An overcurrent on any bridge turns off every bridge. That condition is stored, and only a sleep request or a power-on reset clears it. A thermal event also turns off every bridge, but it clears by itself once the cool flag is seen, so a hysteresis band lies between trip and release. After sleep is released, a settling counter keeps the bridges off and `ready` low until a programmable number of clock cycles has passed. All inputs are asynchronous and pass through a synchronizer before any decision is made.

The fault line is open-drain. The block drives `fault_oe`: a 1 pulls the line low, and a 0 releases it so that an external pull-up brings it high. No interface carries data, so every pin is a plain level signal with no handshake.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While `rst_n` is low and just after it is released, `bridge_en` is all zeros, `ready` is 0 and `fault_oe` is 0.
- R2: After `sleep_n` rises, `ready` becomes 1 exactly SYNC_STAGES+WAKE_CYCLES rising clock edges later and not earlier. `bridge_en` stays all zeros until then.
- R3: SYNC_STAGES+1 edges after `sleep_n` falls, `ready` and `bridge_en` are low. When sleep is released again, the full wake delay of R2 starts from zero.
- R4: If any bit of `oc_det` is high on OC_FILTER consecutive sampled cycles, the overcurrent latch sets SYNC_STAGES+OC_FILTER+1 edges after the rise. It drives `fault_oe` to 1 and every bit of `bridge_en` to 0.
- R5: An `oc_det` pulse shorter than OC_FILTER cycles has no effect. `fault_oe` stays 0 and `bridge_en` stays all ones.
- R6: The overcurrent latch stays set after `oc_det` returns low. It clears SYNC_STAGES+1 edges after `sleep_n` goes low, and it also clears on reset.
- R7: SYNC_STAGES+1 edges after `tsd_over` goes high, the thermal state is hot. `fault_oe` is then 1 and `bridge_en` is all zeros.
- R8: The hot state leaves only when `tsd_under` is high. It clears SYNC_STAGES+1 edges after `tsd_under` rises, as long as `tsd_over` is low. If both flags are high, hot wins.
- R9: A sleep request neither clears nor masks the hot thermal state.
- R10: Overcurrent detections made while sleep is requested are discarded. They do not take effect after wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, stands for a supply cycle |
| sleep_n | input | 1 | Active-low sleep request, asynchronous |
| tsd_over | input | 1 | Temperature above trip threshold, asynchronous |
| tsd_under | input | 1 | Temperature below release threshold, asynchronous |
| oc_det | input | NUM_BRIDGES | Per-bridge overcurrent detector, asynchronous |
| bridge_en | output | NUM_BRIDGES | Per-bridge output enable |
| fault_oe | output | 1 | 1 pulls the open-drain fault line low |
| ready | output | 1 | Wake-up settling complete |

## Verification
Every input passes through SYNC_STAGES flops first, so each result is due a fixed number of edges after its stimulus:
- `ready` is due SYNC_STAGES+WAKE_CYCLES edges after sleep is released.
- A thermal or sleep change is due SYNC_STAGES+1 edges later.
- An overcurrent trip is due SYNC_STAGES+OC_FILTER+1 edges after the detector rises.

The bench changes inputs on the falling edge and counts falling edges, each of which follows exactly one rising edge. It samples one edge before each due point, where the old value must still hold, and again on the due edge itself. The wake-up window and overcurrent pulse lengths 1 to 5 on each bridge are swept, and each expected outcome is derived from those latencies.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
  typedef enum logic {
    THERM_OK  = 1'b0,
    THERM_HOT = 1'b1
  } therm_state_e;
endpackage

// File: rtl/drv_sup_sync.sv
module drv_sup_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/drv_sup_wake.sv
module drv_sup_wake #(
  parameter int WAKE_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  output logic ready
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!awake)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/drv_sup_oc_filter.sv
module drv_sup_oc_filter #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic det,
  output logic hit
);
  localparam int CW = $clog2(FILT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (clear || !det)  run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign hit = (run_q == LIMIT);
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import drv_sup_pkg::*;
#(
  parameter int NUM_BRIDGES = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 300000,
  parameter int OC_FILTER   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sleep_n,
  input  logic                   tsd_over,
  input  logic                   tsd_under,
  input  logic [NUM_BRIDGES-1:0] oc_det,
  output logic [NUM_BRIDGES-1:0] bridge_en,
  output logic                   fault_oe,
  output logic                   ready
);
  localparam int RAW_W = NUM_BRIDGES + 3;

  logic [RAW_W-1:0]       raw_in;
  logic [RAW_W-1:0]       sync_out;
  logic                   sleep_sync_n;
  logic                   over_sync;
  logic                   under_sync;
  logic [NUM_BRIDGES-1:0] oc_sync;
  logic [NUM_BRIDGES-1:0] oc_hit;
  logic                   oc_latched_q;
  therm_state_e           therm_q;
  logic                   therm_hot;

  assign raw_in = {oc_det, tsd_under, tsd_over, sleep_n};

  drv_sup_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_out)
  );

  assign sleep_sync_n = sync_out[0];
  assign over_sync    = sync_out[1];
  assign under_sync   = sync_out[2];
  assign oc_sync      = sync_out[RAW_W-1:3];

  drv_sup_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .awake(sleep_sync_n),
    .ready(ready)
  );

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_oc
    drv_sup_oc_filter #(.FILT(OC_FILTER)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(!sleep_sync_n),
      .det  (oc_sync[b]),
      .hit  (oc_hit[b])
    );
  end

  // Overcurrent: sticky until sleep or power-on reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             oc_latched_q <= 1'b0;
    else if (!sleep_sync_n) oc_latched_q <= 1'b0;
    else if (|oc_hit)       oc_latched_q <= 1'b1;
  end

  // Thermal: trip flag wins, release flag clears; sleep has no say.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          therm_q <= THERM_OK;
    else if (over_sync)  therm_q <= THERM_HOT;
    else if (under_sync) therm_q <= THERM_OK;
  end

  assign therm_hot = (therm_q == THERM_HOT);
  assign fault_oe  = therm_hot | oc_latched_q;
  assign bridge_en = {NUM_BRIDGES{ready & ~fault_oe}};
endmodule

// File: rtl/drv_sup_checker.sv
module drv_sup_checker #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          awake,
  input logic          under,
  input logic          oc_latched,
  input logic          therm_hot,
  input logic          ready,
  input logic          fault_oe,
  input logic [NB-1:0] bridge_en
);
  assert_ready_gates_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (bridge_en == '0));

  assert_sleep_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> !ready);

  assert_oc_kills_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_latched |-> (fault_oe && bridge_en == '0));

  assert_en_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bridge_en) == 0) || ($countones(bridge_en) == NB));

  assert_oc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latched && awake) |=> oc_latched);

  assert_hot_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    therm_hot |-> (fault_oe && bridge_en == '0));

  assert_hot_hyst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_hot && !under) |=> therm_hot);
endmodule

bind drv_fault_supervisor drv_sup_checker #(.NB(NUM_BRIDGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .awake     (sleep_sync_n),
  .under     (under_sync),
  .oc_latched(oc_latched_q),
  .therm_hot (therm_hot),
  .ready     (ready),
  .fault_oe  (fault_oe),
  .bridge_en (bridge_en)
);

// File: tb/drv_fault_supervisor_tb.sv
`timescale 1ns/1ps
module drv_fault_supervisor_tb_top;
  localparam int NB = 2;
  localparam int SY = 2;
  localparam int W  = 8;
  localparam int F  = 3;
  localparam logic [NB-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_n = 1'b0;
  logic          tsd_over = 1'b0;
  logic          tsd_under = 1'b0;
  logic [NB-1:0] oc_det = '0;
  logic [NB-1:0] bridge_en;
  logic          fault_oe;
  logic          ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  drv_fault_supervisor #(
    .NUM_BRIDGES(NB), .SYNC_STAGES(SY), .WAKE_CYCLES(W), .OC_FILTER(F)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .tsd_over(tsd_over),
    .tsd_under(tsd_under), .oc_det(oc_det), .bridge_en(bridge_en),
    .fault_oe(fault_oe), .ready(ready)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wake_full();
    sleep_n = 1'b1;
    step(SY + W);
  endtask

  initial begin
    step(3);
    chk("R1 ready", 32'(ready), 0);
    chk("R1 en", 32'(bridge_en), 0);
    chk("R1 fault", 32'(fault_oe), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 en after release", 32'(bridge_en), 0);

    // R2: sweep the whole wake window edge by edge
    sleep_n = 1'b1;
    for (int n = 1; n <= SY + W + 3; n++) begin
      step(1);
      chk("R2 ready", 32'(ready), 32'(n >= SY + W));
      chk("R2 en", 32'(bridge_en), (n >= SY + W) ? 32'(ALL) : 0);
    end

    // R3: sleep latency and wake restart
    sleep_n = 1'b0;
    step(SY);
    chk("R3 ready before due", 32'(ready), 1);
    step(1);
    chk("R3 ready", 32'(ready), 0);
    chk("R3 en", 32'(bridge_en), 0);
    sleep_n = 1'b1;
    step(SY + W - 1);
    chk("R3 restart early", 32'(ready), 0);
    step(1);
    chk("R3 restart", 32'(ready), 1);

    // R4: exact overcurrent latency on bridge 0
    oc_det = 2'b01;
    step(SY + F);
    chk("R4 before due", 32'(fault_oe), 0);
    chk("R4 en before due", 32'(bridge_en), 32'(ALL));
    step(1);
    chk("R4 fault", 32'(fault_oe), 1);
    chk("R4 en", 32'(bridge_en), 0);
    oc_det = '0;
    step(6);
    chk("R6 sticky", 32'(fault_oe), 1);
    sleep_n = 1'b0;
    step(SY);
    chk("R6 before clear", 32'(fault_oe), 1);
    step(1);
    chk("R6 cleared", 32'(fault_oe), 0);
    wake_full();
    chk("R6 en back", 32'(bridge_en), 32'(ALL));

    // R4/R5: pulse-length sweep on each bridge
    for (int b = 0; b < NB; b++) begin
      for (int k = 1; k <= 5; k++) begin
        oc_det[b] = 1'b1;
        step(k);
        oc_det = '0;
        step(F + 4);
        if (k >= F) begin
          chk("R4 sweep fault", 32'(fault_oe), 1);
          chk("R4 sweep en", 32'(bridge_en), 0);
          sleep_n = 1'b0;
          step(SY + 1);
          wake_full();
          chk("R6 sweep recover", 32'(bridge_en), 32'(ALL));
        end else begin
          chk("R5 short fault", 32'(fault_oe), 0);
          chk("R5 short en", 32'(bridge_en), 32'(ALL));
        end
      end
    end

    // R10: overcurrent while asleep is discarded
    sleep_n = 1'b0;
    step(SY + 1);
    oc_det = ALL;
    step(10);
    oc_det = '0;
    step(SY + 1);
    wake_full();
    chk("R10 fault", 32'(fault_oe), 0);
    chk("R10 en", 32'(bridge_en), 32'(ALL));

    // R7: thermal trip latency
    tsd_over = 1'b1;
    step(SY);
    chk("R7 before due", 32'(bridge_en), 32'(ALL));
    step(1);
    chk("R7 fault", 32'(fault_oe), 1);
    chk("R7 en", 32'(bridge_en), 0);
    // R8: dropping the trip flag alone does not release
    tsd_over = 1'b0;
    step(6);
    chk("R8 hold", 32'(fault_oe), 1);
    // R9: sleep neither clears nor masks hot
    sleep_n = 1'b0;
    step(4);
    chk("R9 fault asleep", 32'(fault_oe), 1);
    wake_full();
    step(2);
    chk("R9 ready", 32'(ready), 1);
    chk("R9 fault", 32'(fault_oe), 1);
    chk("R9 en", 32'(bridge_en), 0);
    // R8: release flag clears
    tsd_under = 1'b1;
    step(SY);
    chk("R8 before release", 32'(fault_oe), 1);
    step(1);
    chk("R8 released", 32'(fault_oe), 0);
    chk("R8 en", 32'(bridge_en), 32'(ALL));
    // R8: trip wins when both flags are high
    tsd_over = 1'b1;
    step(SY + 1);
    chk("R8 priority", 32'(fault_oe), 1);
    tsd_over = 1'b0;
    step(SY + 1);
    chk("R8 priority release", 32'(fault_oe), 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule